// File: doc/BRIEF.md
# Bus Error Capture Unit

This block records the first failing transaction seen on a bus interface port and reports it to software through an interrupt line. Detection logic elsewhere raises one pulse bit for each kind of error, together with the 64-bit address, the 64-bit data and a 32-bit command or parity word of the transaction. The unit sets the matching sticky cause bit. When no cause was pending before, it also stores the transaction details in five capture words.

Software sets up an enable mask, reads the cause and capture words through a small register port, and acknowledges errors by writing the bitwise inverse of the cause value it read. A write of 0 to a cause bit clears it and a write of 1 leaves it as it is. Because of this, an error that arrives between the read and the write stays pending. The capture words keep the first error until every cause bit has been cleared. The interrupt output is registered.

Top module: `bus_err_capture`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the cause, mask and all five capture words read 0 and irq is low.
- R2: A 1 on bit b of err_pulse at a clock edge sets cause bit b, and the bit can be read after that edge. A set bit stays set until software clears it.
- R3: A register write with reg_sel=0 (cause) clears each cause bit whose written value is 0 and leaves each bit written with 1 unchanged. Writing the inverse of a value just read clears exactly the bits that were read as set, and writing all zeros clears every bit.
- R4: An err_pulse bit that is high at the same edge as a clearing write to the cause register leaves its cause bit set.
- R5: When err_pulse is nonzero and the cause register is all zero before the edge, the edge loads the capture words: sel 2 = err_addr[31:0], sel 3 = err_addr[63:32], sel 4 = err_data[31:0], sel 5 = err_data[63:32], sel 6 = err_attr.
- R6: While any cause bit is set, the capture words do not change, even when new errors arrive.
- R7: Once every cause bit has been cleared, the next error loads the capture words again (R5).
- R8: A write with reg_sel=1 loads the mask, which reads back on sel 1. Writes to sel 2 to 7 have no effect.
- R9: irq goes high one clock edge after the state where (cause AND mask) first becomes nonzero, and goes low one edge after that state becomes zero. Cause bits whose mask bit is 0 never raise irq, for example bit 0 under mask 0x000000FE.
- R10: reg_rdata is combinational from reg_sel, and sel 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse | input | CAUSE_W (32) | One-cycle error pulses, one bit per error kind |
| err_addr | input | 2*WORD_W (64) | Address of the transaction that goes with err_pulse |
| err_data | input | 2*WORD_W (64) | Data of the transaction that goes with err_pulse |
| err_attr | input | WORD_W (32) | Command, attribute or parity word that goes with err_pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 cause, 1 mask, 2..6 capture words, 7 unused |
| reg_wdata | input | WORD_W (32) | Register write data |
| reg_rdata | output | WORD_W (32) | Read data of the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that err_pulse and its address, data and attribute words are valid together in the same cycle. They also assume that software reaches the cause register only through reg_wr with reg_sel=0. The bench drives every input on the falling edge. It gives every error pulse its own distinct address, data and attribute values, so a stale capture shows up as a wrong word. It steps one pulse bit at a time through all 32 cause positions under both enable patterns (0x000000FE and 0x003C0C24). In each round it lands a clearing write in the same cycle as a new error.

// File: rtl/bec_pkg.sv
// Package: shared register select encoding and sizes for the bus error
// capture unit. Assumes a 3-bit register select port.
package bec_pkg;
    typedef enum logic [2:0] {
        SEL_CAUSE   = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_ADDR_LO = 3'd2,
        SEL_ADDR_HI = 3'd3,
        SEL_DATA_LO = 3'd4,
        SEL_DATA_HI = 3'd5,
        SEL_ATTR    = 3'd6,
        SEL_NONE    = 3'd7
    } bec_sel_e;

    // Number of words frozen on the first error.
    localparam int CAPT_WORDS = 5;
endpackage

// File: rtl/bec_cause_reg.sv
// Module: sticky cause register. Error pulses set bits; a software write
// clears the bits written as zero. Assumes set_i is valid each cycle and
// clr_wr_i is a single-cycle strobe. Setting wins over clearing per bit.
module bec_cause_reg #(
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic               clr_wr_i,
    input  logic [CAUSE_W-1:0] clr_val_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [CAUSE_W-1:0] kept;

    // Bits surviving a possible write-zero-to-clear.
    always_comb begin
        kept = clr_wr_i ? (cause_o & clr_val_i) : cause_o;
    end

    // Cause state: survivors plus new errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o <= '0;
        end else begin
            cause_o <= kept | set_i;
        end
    end

    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((cause_o & $past(set_i)) == $past(set_i))); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R2
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((cause_o & ~$past(clr_val_i) & ~$past(set_i)) == '0)); // R3
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && (set_i != '0)) |=> ((cause_o & $past(set_i)) != '0)); // R4
endmodule

// File: rtl/bec_capture_bank.sv
// Module: bank of capture words that load together on load_i and otherwise
// hold. Assumes words_i is valid in the cycle load_i is high.
module bec_capture_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load_i,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]   words_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]   words_o
);
    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            // One capture word: load on request, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words_o[g] <= '0;
                end else if (load_i) begin
                    words_o[g] <= words_i[g];
                end
            end
        end
    endgenerate

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (words_o == $past(words_i))); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(words_o)); // R6
endmodule

// File: rtl/bec_irq_gen.sv
// Module: registered interrupt request from enabled cause bits. Assumes
// cause_i and mask_i are register outputs in the same clock domain.
module bec_irq_gen #(
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [CAUSE_W-1:0] mask_i,
    output logic               irq_o
);
    logic pending;

    // Any enabled cause pending.
    always_comb begin
        pending = |(cause_i & mask_i);
    end

    // Register the request for a clean output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= pending;
        end
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(cause_i & mask_i) != '0)); // R9
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_i & mask_i) == '0) |=> !irq_o); // R9
endmodule

// File: rtl/bus_err_capture.sv
// Module: top of the bus error capture unit. Holds the mask register, routes
// error pulses into the sticky cause register, freezes the transaction
// details of the first error and drives a registered interrupt. Assumes the
// error detectors present address, data and attribute alongside err_pulse,
// and that CAUSE_W <= WORD_W.
module bus_err_capture
    import bec_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int CAUSE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CAUSE_W-1:0]  err_pulse,
    input  logic [2*WORD_W-1:0] err_addr,
    input  logic [2*WORD_W-1:0] err_data,
    input  logic [WORD_W-1:0]   err_attr,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq
);
    localparam int NW = CAPT_WORDS;

    generate
        if (CAUSE_W > WORD_W) begin : g_bad_width
            $error("CAUSE_W must not exceed WORD_W");
        end
    endgenerate

    logic [CAUSE_W-1:0]          cause_q;
    logic [CAUSE_W-1:0]          mask_q;
    logic                        cause_wr;
    logic                        mask_wr;
    logic                        capt_load;
    logic [NW-1:0][WORD_W-1:0]   capt_in;
    logic [NW-1:0][WORD_W-1:0]   capt_q;
    bec_sel_e                    sel;

    // Decode the register port.
    always_comb begin
        sel      = bec_sel_e'(reg_sel);
        cause_wr = reg_wr && (sel == SEL_CAUSE);
        mask_wr  = reg_wr && (sel == SEL_MASK);
    end

    // Capture loads only when nothing is pending yet.
    always_comb begin
        capt_load  = (err_pulse != '0) && (cause_q == '0);
        capt_in[0] = err_addr[WORD_W-1:0];
        capt_in[1] = err_addr[2*WORD_W-1:WORD_W];
        capt_in[2] = err_data[WORD_W-1:0];
        capt_in[3] = err_data[2*WORD_W-1:WORD_W];
        capt_in[4] = err_attr;
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= reg_wdata[CAUSE_W-1:0];
        end
    end

    bec_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (err_pulse),
        .clr_wr_i  (cause_wr),
        .clr_val_i (reg_wdata[CAUSE_W-1:0]),
        .cause_o   (cause_q)
    );

    bec_capture_bank #(.WORD_W(WORD_W), .NUM_WORDS(NW)) u_capt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (capt_load),
        .words_i (capt_in),
        .words_o (capt_q)
    );

    bec_irq_gen #(.CAUSE_W(CAUSE_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_q),
        .mask_i  (mask_q),
        .irq_o   (irq)
    );

    // Read multiplexer.
    always_comb begin
        case (sel)
            SEL_CAUSE:   reg_rdata = WORD_W'(cause_q);
            SEL_MASK:    reg_rdata = WORD_W'(mask_q);
            SEL_ADDR_LO: reg_rdata = capt_q[0];
            SEL_ADDR_HI: reg_rdata = capt_q[1];
            SEL_DATA_LO: reg_rdata = capt_q[2];
            SEL_DATA_HI: reg_rdata = capt_q[3];
            SEL_ATTR:    reg_rdata = capt_q[4];
            default:     reg_rdata = '0;
        endcase
    end

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != '0) |=> $stable(capt_q)); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q == '0) && (err_pulse != '0)) |=> (capt_q[0] == $past(err_addr[WORD_W-1:0]))); // R7
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(reg_wdata[CAUSE_W-1:0]))); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_wr) |=> $stable(mask_q)); // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 3'd7) |-> (reg_rdata == '0)); // R10
endmodule

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] err_pulse;
    logic [63:0] err_addr;
    logic [63:0] err_data;
    logic [31:0] err_attr;
    logic        reg_wr;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_err_capture u_dut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_addr(err_addr),
        .err_data(err_data), .err_attr(err_attr), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] b, input logic [63:0] a,
                         input logic [63:0] d, input logic [31:0] t);
        err_pulse = b; err_addr = a; err_data = d; err_attr = t;
        @(negedge clk);
        err_pulse = '0;
    endtask

    task automatic chk_capt(input string req, input logic [63:0] a,
                            input logic [63:0] d, input logic [31:0] t);
        logic [31:0] v;
        rd(3'd2, v); chk(req, v, a[31:0]);
        rd(3'd3, v); chk(req, v, a[63:32]);
        rd(3'd4, v); chk(req, v, d[31:0]);
        rd(3'd5, v); chk(req, v, d[63:32]);
        rd(3'd6, v); chk(req, v, t);
    endtask

    function automatic logic [63:0] mk_addr(input int n);
        return {32'hA000_0000 + 32'(n), 32'h1000_0000 + 32'(n * 3)};
    endfunction
    function automatic logic [63:0] mk_data(input int n);
        return {32'hD000_0000 ^ 32'(n * 7), 32'h5500_0000 + 32'(n)};
    endfunction
    function automatic logic [31:0] mk_attr(input int n);
        return 32'hC0DE_0000 | 32'(n);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] seen;
        logic [31:0] masks [2];
        int tag;
        masks[0] = 32'h0000_00FE;
        masks[1] = 32'h003C_0C24;
        rst_n = 1'b0; err_pulse = '0; err_addr = '0; err_data = '0; err_attr = '0;
        reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(3'd0, v); chk("R1 cause", v, 32'h0);
        rd(3'd1, v); chk("R1 mask", v, 32'h0);
        chk_capt("R1 capture", 64'h0, 64'h0, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        // R10: unused select
        rd(3'd7, v); chk("R10 unused read", v, 32'h0);
        tag = 0;
        for (int m = 0; m < 2; m++) begin
            wr(3'd1, 32'h0);
            rd(3'd1, v); chk("R8 mask zeroed", v, 32'h0);
            wr(3'd1, masks[m]);
            rd(3'd1, v); chk("R8 mask load", v, masks[m]);
            for (int i = 0; i < 32; i++) begin
                int j;
                int k;
                int t0;
                j = (i + 5) % 32;
                k = (i + 11) % 32;
                t0 = tag;
                // R5/R7: first error after all clear loads the capture words
                pulse(32'h1 << i, mk_addr(t0), mk_data(t0), mk_attr(t0));
                rd(3'd0, v); chk("R2 cause set", v, 32'h1 << i);
                chk_capt(tag == 0 ? "R5 capture" : "R7 reload", mk_addr(t0), mk_data(t0), mk_attr(t0));
                @(negedge clk);
                chk("R9 irq per mask", {31'h0, irq}, {31'h0, masks[m][i]});
                // R6: second error does not disturb capture
                pulse(32'h1 << j, mk_addr(t0 + 1), mk_data(t0 + 1), mk_attr(t0 + 1));
                rd(3'd0, seen); chk("R2 cause accumulates", seen, (32'h1 << i) | (32'h1 << j));
                chk_capt("R6 frozen", mk_addr(t0), mk_data(t0), mk_attr(t0));
                // R8: writes to capture words and unused select ignored
                wr(3'd2, 32'hFFFF_FFFF);
                wr(3'd7, 32'hFFFF_FFFF);
                rd(3'd2, v); chk("R8 capture write ignored", v, mk_addr(t0)[31:0]);
                rd(3'd1, v); chk("R8 mask unchanged", v, masks[m]);
                // R3: writing ones leaves causes unchanged
                wr(3'd0, 32'hFFFF_FFFF);
                rd(3'd0, v); chk("R3 ones keep", v, seen);
                // R4: complement clear in same cycle as a new error
                err_pulse = 32'h1 << k; err_addr = mk_addr(t0 + 2);
                err_data = mk_data(t0 + 2); err_attr = mk_attr(t0 + 2);
                wr(3'd0, ~seen);
                err_pulse = '0;
                rd(3'd0, v); chk("R4 new error survives clear", v, 32'h1 << k);
                chk_capt("R6 frozen at clear", mk_addr(t0), mk_data(t0), mk_attr(t0));
                @(negedge clk);
                chk("R9 irq after ack", {31'h0, irq}, {31'h0, masks[m][k]});
                // R3: all-zero write clears everything
                wr(3'd0, 32'h0);
                rd(3'd0, v); chk("R3 zero clears", v, 32'h0);
                @(negedge clk);
                chk("R9 irq drops", {31'h0, irq}, 32'h0);
                tag = tag + 3;
            end
        end
        // R1: reset again clears a pending state
        pulse(32'h8000_0001, mk_addr(900), mk_data(900), mk_attr(900));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd0, v); chk("R1 cause after reset", v, 32'h0);
        rd(3'd1, v); chk("R1 mask after reset", v, 32'h0);
        chk_capt("R1 capture after reset", 64'h0, 64'h0, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule